// File: doc/BRIEF.md
# Multicontext LUT Logic Block

This block is one time-shared logic element. A single K-input lookup table is reused over several contexts. Each context has its own stored instruction. A context counter steps through the contexts one per clock cycle. In each cycle the active instruction picks K values from a small set of candidate signals, evaluates the lookup table on them and registers the result.

The block's own registered result is one of the candidates. An instruction can therefore consume a value that an earlier context produced. Every candidate signal also feeds a short history chain on the input side. An instruction can read a candidate as it is now or as it was a few running cycles ago. A multi-level function can be split across the contexts without holding intermediate values on extra outputs.

Instructions are loaded through a write port while the block is stopped. When the run enable is low, the block freezes its counter, output and history.

Top module: `mctx_lut_block`

## Requirements
- R1: While reset is asserted, ctx_o is 0 and out_o is 0, and the instruction store and the history chains are cleared.
- R2: While run_en is high, ctx_o advances by one per clock and wraps from NUM_CTX-1 to 0. While run_en is low, ctx_o holds.
- R3: With run_en low, a cycle with cfg_we high stores cfg_data as the instruction of context cfg_addr. A write attempted while run_en is high leaves the store unchanged.
- R4: Instruction layout:
  - Bits [2^K-1:0] hold the truth table. The result is bit number (sum over k of input_k << k).
  - LUT input k owns a field starting at bit 2^K + k*(S+T), where S = log2(NUM_CAND) and T = log2(RT_DEPTH).
  - The low S bits of that field are a binary candidate select. The next T bits are a history tap.
- R5: Candidate 0 is the block's own registered output. Candidate n (n >= 1) is cand_i[n-1].
- R6: For a candidate, tap 0 gives its present value and tap j gives its value j running cycles earlier. While run_en is low the history does not shift.
- R7: The result of the context shown on ctx_o appears on out_o after the next rising clock edge with run_en high. It holds for the following cycle. While run_en is low, out_o does not change.
- R8: A context reads no value that it computes itself. Candidate 0 at tap 0 yields the previous context's result, and tap 1 yields the result from two contexts back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: step contexts; low: freeze and allow loading |
| cfg_we | input | 1 | Instruction write strobe |
| cfg_addr | input | log2(NUM_CTX) | Context number being written |
| cfg_data | input | instruction width | Instruction word |
| cand_i | input | NUM_CAND-1 | External candidate signals (candidates 1 and up) |
| ctx_o | output | log2(NUM_CTX) | Context evaluated in the current cycle |
| out_o | output | 1 | Registered LUT result |

## Verification
The assertions assume that rst_n is applied before any other activity, and that cfg_addr names an existing context whenever cfg_we is high. They also assume that instructions are loaded before run_en rises. The stimulus drives every input at the falling edge. It writes only to valid context numbers. It loads the full program while run_en is low, and it makes exactly one write attempt while running, in order to exercise the ignore rule. Pauses with run_en low are inserted in the middle of a sweep. During those pauses the external candidates are deliberately changed, which shows that the frozen history still supplies the pre-pause values.

// File: rtl/mctx_pkg.sv
package mctx_pkg;

   // Total instruction word width: truth table plus K select/tap fields.
   function automatic int instr_width(int k, int ncand, int depth);
      return (1 << k) + k * ($clog2(ncand) + $clog2(depth));
   endfunction

   // LSB of the select/tap field that belongs to LUT input idx.
   function automatic int field_lsb(int k, int ncand, int depth, int idx);
      return (1 << k) + idx * ($clog2(ncand) + $clog2(depth));
   endfunction

endpackage

// File: rtl/mctx_ctx_seq.sv
module mctx_ctx_seq #(
   parameter int NUM_CTX = 4,
   localparam int CW = $clog2(NUM_CTX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   output logic [CW-1:0] ctx_q
);

   localparam logic [CW-1:0] LAST = CW'(NUM_CTX - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctx_q <= '0;
      end else if (run_en) begin
         ctx_q <= (ctx_q == LAST) ? '0 : ctx_q + 1'b1;
      end
   end

   // R2: the last context is followed by context 0
   assert_ctx_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && ctx_q == LAST) |=> (ctx_q == '0));

   // R2: any other context steps up by exactly one
   assert_ctx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && ctx_q != LAST) |=> (ctx_q == $past(ctx_q) + 1'b1));

   // R2: the counter holds while stopped
   assert_ctx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(ctx_q));

endmodule

// File: rtl/mctx_cfg_store.sv
module mctx_cfg_store #(
   parameter int NUM_CTX = 4,
   parameter int IW      = 36,
   localparam int CW     = $clog2(NUM_CTX)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic          we,
   input  logic [CW-1:0] waddr,
   input  logic [IW-1:0] wdata,
   input  logic [CW-1:0] raddr,
   output logic [IW-1:0] rdata
);

   logic [NUM_CTX-1:0][IW-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q <= '0;
      end else if (we && !run_en && (int'(waddr) < NUM_CTX)) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign rdata = mem_q[raddr];

   // R3: nothing in the store changes while contexts are stepping
   assert_store_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> $stable(mem_q));

endmodule

// File: rtl/mctx_in_retime.sv
module mctx_in_retime #(
   parameter int NUM_CAND = 8,
   parameter int RT_DEPTH = 4,
   parameter int LUT_K    = 4,
   localparam int SW      = $clog2(NUM_CAND),
   localparam int TW      = $clog2(RT_DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  run_en,
   input  logic [NUM_CAND-1:0]   cand_vec,
   input  logic [LUT_K*SW-1:0]   sel_flat,
   input  logic [LUT_K*TW-1:0]   tap_flat,
   output logic [LUT_K-1:0]      lut_in
);

   // hist_q[j] holds the candidate vector from j+1 running cycles ago
   logic [RT_DEPTH-2:0][NUM_CAND-1:0] hist_q;
   logic [RT_DEPTH-1:0][NUM_CAND-1:0] tapv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else if (run_en) begin
         hist_q[0] <= cand_vec;
         for (int j = 1; j < RT_DEPTH - 1; j++) begin
            hist_q[j] <= hist_q[j-1];
         end
      end
   end

   assign tapv[0] = cand_vec;

   generate
      for (genvar j = 1; j < RT_DEPTH; j++) begin : g_tap
         assign tapv[j] = hist_q[j-1];
      end
      for (genvar k = 0; k < LUT_K; k++) begin : g_pick
         logic [SW-1:0] sel_k;
         logic [TW-1:0] tap_k;
         assign sel_k     = sel_flat[k*SW +: SW];
         assign tap_k     = tap_flat[k*TW +: TW];
         assign lut_in[k] = tapv[tap_k][sel_k];
      end
   endgenerate

   // R6: the first history stage captures what tap 0 showed one running cycle ago
   assert_tap_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |=> (hist_q[0] == $past(cand_vec)));

   // R6: history freezes while stopped
   assert_tap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(hist_q));

endmodule

// File: rtl/mctx_lut_eval.sv
module mctx_lut_eval #(
   parameter int LUT_K = 4,
   localparam int TTW  = 1 << LUT_K
) (
   input  logic [TTW-1:0]   truth,
   input  logic [LUT_K-1:0] idx,
   output logic             y
);

   assign y = truth[idx];

endmodule

// File: rtl/mctx_lut_block.sv
module mctx_lut_block
   import mctx_pkg::*;
#(
   parameter int NUM_CTX  = 4,
   parameter int LUT_K    = 4,
   parameter int NUM_CAND = 8,
   parameter int RT_DEPTH = 4
) (
   input  logic                                           clk,
   input  logic                                           rst_n,
   input  logic                                           run_en,
   input  logic                                           cfg_we,
   input  logic [$clog2(NUM_CTX)-1:0]                     cfg_addr,
   input  logic [instr_width(LUT_K,NUM_CAND,RT_DEPTH)-1:0] cfg_data,
   input  logic [NUM_CAND-2:0]                            cand_i,
   output logic [$clog2(NUM_CTX)-1:0]                     ctx_o,
   output logic                                           out_o
);

   localparam int CW  = $clog2(NUM_CTX);
   localparam int SW  = $clog2(NUM_CAND);
   localparam int TW  = $clog2(RT_DEPTH);
   localparam int TTW = 1 << LUT_K;
   localparam int IW  = instr_width(LUT_K, NUM_CAND, RT_DEPTH);

   // elaboration-time parameter checks
   generate
      if (NUM_CTX < 4 || NUM_CTX > 8) begin : g_bad_ctx
         $error("NUM_CTX must lie in 4..8");
      end
      if (LUT_K < 4 || LUT_K > 6) begin : g_bad_k
         $error("LUT_K must lie in 4..6");
      end
      if (NUM_CAND < 2 || (1 << SW) != NUM_CAND) begin : g_bad_cand
         $error("NUM_CAND must be a power of two, at least 2");
      end
      if (RT_DEPTH < 2 || (1 << TW) != RT_DEPTH) begin : g_bad_depth
         $error("RT_DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [CW-1:0]         ctx_q;
   logic [IW-1:0]         instr;
   logic [LUT_K*SW-1:0]   sel_flat;
   logic [LUT_K*TW-1:0]   tap_flat;
   logic [NUM_CAND-1:0]   cand_vec;
   logic [LUT_K-1:0]      lut_in;
   logic                  lut_y;
   logic                  out_q;

   // candidate 0 is the registered result itself
   assign cand_vec = {cand_i, out_q};

   generate
      for (genvar k = 0; k < LUT_K; k++) begin : g_dec
         localparam int LSB = field_lsb(LUT_K, NUM_CAND, RT_DEPTH, k);
         assign sel_flat[k*SW +: SW] = instr[LSB +: SW];
         assign tap_flat[k*TW +: TW] = instr[LSB + SW +: TW];
      end
   endgenerate

   mctx_ctx_seq #(.NUM_CTX(NUM_CTX)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .ctx_q  (ctx_q)
   );

   mctx_cfg_store #(.NUM_CTX(NUM_CTX), .IW(IW)) u_store (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .we     (cfg_we),
      .waddr  (cfg_addr),
      .wdata  (cfg_data),
      .raddr  (ctx_q),
      .rdata  (instr)
   );

   mctx_in_retime #(.NUM_CAND(NUM_CAND), .RT_DEPTH(RT_DEPTH), .LUT_K(LUT_K)) u_rt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .cand_vec (cand_vec),
      .sel_flat (sel_flat),
      .tap_flat (tap_flat),
      .lut_in   (lut_in)
   );

   mctx_lut_eval #(.LUT_K(LUT_K)) u_lut (
      .truth (instr[TTW-1:0]),
      .idx   (lut_in),
      .y     (lut_y)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= 1'b0;
      end else if (run_en) begin
         out_q <= lut_y;
      end
   end

   assign ctx_o = ctx_q;
   assign out_o = out_q;

   // R7: the registered result does not move while stopped
   assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(out_o));

endmodule

// File: tb/test_mctx_lut_block.sv
module test_mctx_lut_block;

   localparam int NC = 4;
   localparam int K  = 4;
   localparam int N  = 8;
   localparam int D  = 4;
   localparam int CW = 2;
   localparam int IW = 36;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          run_en;
   logic          cfg_we;
   logic [CW-1:0] cfg_addr;
   logic [IW-1:0] cfg_data;
   logic [N-2:0]  cand_i;
   logic [CW-1:0] ctx_o;
   logic          out_o;

   always #4 clk = ~clk;   // 125 MHz

   mctx_lut_block #(.NUM_CTX(NC), .LUT_K(K), .NUM_CAND(N), .RT_DEPTH(D)) i_mctx_lut_block (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .cfg_we   (cfg_we),
      .cfg_addr (cfg_addr),
      .cfg_data (cfg_data),
      .cand_i   (cand_i),
      .ctx_o    (ctx_o),
      .out_o    (out_o)
   );

   typedef struct {int due; logic val; string req;} exp_t;
   exp_t sbq[$];
   exp_t cur;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc   = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(int act, int expv, string req, string what);
      n_cmp++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
         cur = sbq.pop_front();
         chk(int'(out_o), int'(cur.val), cur.req, "out_o");
      end
   end

   // golden model state, indexed by running cycle
   logic       res[$];
   logic [6:0] inp[$];
   int         rk = 0;
   bit         ctx0_xor = 1'b0;

   // R4 instruction word: table [15:0], input k field at 16+5k = {tap[1:0], sel[2:0]}
   function automatic logic [IW-1:0] mk(logic [15:0] tt, logic [2:0] s0, logic [1:0] t0,
                                        logic [2:0] s1, logic [1:0] t1);
      logic [IW-1:0] w;
      w = '0;
      w[15:0]   = tt;
      w[16 +: 3] = s0;
      w[19 +: 2] = t0;
      w[21 +: 3] = s1;
      w[24 +: 2] = t1;
      return w;
   endfunction

   function automatic logic [6:0] stim(int n);
      return 7'((n * 53 + 17) ^ ((n * n * 7) >> 1));
   endfunction

   task automatic wr(logic [CW-1:0] a, logic [IW-1:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // driver: one running cycle, pushes the expected result
   task automatic run_cycle(string req_in = "", bit try_wr = 1'b0);
      logic [6:0] s;
      logic       e;
      string      req;
      s = stim(rk);
      cand_i = s;
      chk(int'(ctx_o), rk % NC, "R2", "ctx_o");
      if (try_wr) begin
         cfg_we = 1'b1; cfg_addr = 2'd1; cfg_data = '0;
      end
      inp.push_back(s);
      case (rk % NC)
         0: e = ctx0_xor ? (s[0] ^ s[1]) : (s[0] & s[1]);         // a,b = cand 1,2
         1: e = s[2] & ~s[3];                                      // c & ~d
         2: e = res[rk-2] ^ res[rk-1];                             // own result, taps 1 and 0
         default: e = res[rk-1] & inp[rk-3][4];                    // e three cycles back
      endcase
      case (rk % NC)
         0, 1: req = "R4";
         2: req = "R5 R8";
         default: req = "R6";
      endcase
      if (req_in != "") req = req_in;
      res.push_back(e);
      sbq.push_back('{cyc + 1, e, req});
      rk++;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pause(int n);
      logic last;
      last = res[res.size()-1];
      run_en = 1'b0;
      for (int i = 0; i < n; i++) begin
         cand_i = ~stim(rk + 100 + i);
         @(posedge clk); @(negedge clk);
         chk(int'(out_o), int'(last), "R7", "out_o hold");
         chk(int'(ctx_o), rk % NC, "R2", "ctx_o hold");
      end
      run_en = 1'b1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; run_en = 1'b0; cfg_we = 1'b0;
      cfg_addr = '0; cfg_data = '0; cand_i = '0;
      repeat (3) @(negedge clk);
      chk(int'(ctx_o), 0, "R1", "ctx_o in reset");
      chk(int'(out_o), 0, "R1", "out_o in reset");
      rst_n = 1'b1;
      @(negedge clk);

      // R3: load program while stopped
      wr(2'd0, mk(16'h8888, 3'd1, 2'd0, 3'd2, 2'd0));  // a & b
      wr(2'd1, mk(16'h2222, 3'd3, 2'd0, 3'd4, 2'd0));  // c & ~d
      wr(2'd2, mk(16'h6666, 3'd0, 2'd1, 3'd0, 2'd0));  // prev2 ^ prev1
      wr(2'd3, mk(16'h8888, 3'd0, 2'd0, 3'd5, 2'd3));  // prev1 & e(t-3)
      chk(int'(ctx_o), 0, "R2", "ctx_o while loading");
      chk(int'(out_o), 0, "R7", "out_o while loading");

      run_en = 1'b1;
      for (int i = 0; i < 8; i++) run_cycle();
      for (int i = 0; i < 2; i++) run_cycle();
      pause(3);                                   // R6 frozen history across pause
      for (int i = 0; i < 6; i++) run_cycle();

      run_cycle("R3", 1'b1);                      // ignored write to context 1
      for (int i = 0; i < 8; i++) run_cycle("R3");

      while (rk % NC != 0) run_cycle();
      run_en = 1'b0;
      wr(2'd0, mk(16'h6666, 3'd1, 2'd0, 3'd2, 2'd0));  // a ^ b
      ctx0_xor = 1'b1;
      run_en = 1'b1;
      for (int i = 0; i < 8; i++) run_cycle("R3");
      for (int i = 0; i < 4; i++) run_cycle();

      run_en = 1'b0;
      repeat (2) @(negedge clk);
      chk(sbq.size(), 0, "R7", "scoreboard drained");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule